// File: doc/BRIEF.md
# Transport Stream Output Port

This block is the last stage of a packet receiver. Decoded transport-stream bytes come in one at a time with a valid/ready handshake. Each byte carries three side flags: packet start, uncorrectable packet and superframe start. The block drives an output port with a generated output clock, a data bus, a data-enable, a packet-sync pulse, an error flag and a frame-start pulse.

The output clock is a toggle of the system clock, so one output clock period is two system cycles. Data changes as the output clock falls and is stable across its rising edge. The port has three modes:
- **Parallel:** a whole byte goes out in each output clock period.
- **Serial:** each byte goes out on bit 0, most significant bit first, over eight output clock periods.
- **Bypass:** a raw bit stream and its clock are passed to bit 0 and to the output clock pin, one register stage late.

Each of the four control outputs has its own polarity control. A requested mode takes effect only at a packet boundary.

Top module: `tsout_port`

## Requirements
- R1: Outside bypass, `out_clk` toggles on every system clock, starting low after reset. In parallel mode (`cfg_mode` 2'b00, and 2'b11 acts the same), each accepted byte appears on `out_data` for one output clock period. The byte changes as `out_clk` falls and holds through its rising edge.
- R2: The raw data-enable is high in exactly those output clock periods that carry a byte (parallel) or a bit (serial). When no byte is available it is low, and psync, error and frame-start are also low then.
- R3: Raw packet-sync is high only in the first output period of a byte accepted with `in_pkt_start`. In serial mode this is only the first bit of that byte.
- R4: Raw error is high in every output period of a packet whose start byte had `in_uncorr` set. `in_uncorr` on any other byte of the packet is ignored.
- R5: Raw frame-start is high for exactly one output clock period: the first period of a start byte that had `in_frame_start` set.
- R6: In serial mode (`cfg_mode` 2'b01), each byte is sent on `out_data[0]` most significant bit first, over 8 output clock periods. `out_data[7:1]` is 0 while enable is active.
- R7: Each pin equals its raw value XOR a bit of `cfg_inv`: bit 0 controls enable, bit 1 psync, bit 2 error and bit 3 frame-start. While idle, each of these pins therefore equals its `cfg_inv` bit.
- R8: In bypass mode (`cfg_mode` 2'b10), `out_data[0]` and `out_clk` equal `byp_bit` and `byp_clk` delayed by one system clock. The upper data bits are 0, every raw control is inactive and `in_ready` stays low.
- R9: A packet is 188 bytes, counted from a byte with `in_pkt_start`. A change of `cfg_mode` takes effect only when no packet is in progress, so a packet is never split across modes.
- R10: During reset, `out_clk`, `out_data` and `in_ready` are 0, every raw control is inactive and the mode is parallel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Requested mode: 00/11 parallel, 01 serial, 10 bypass |
| cfg_inv | input | 4 | Polarity: [0] enable, [1] psync, [2] error, [3] frame-start |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Port accepts a byte this cycle |
| in_data | input | 8 | Input byte |
| in_pkt_start | input | 1 | Byte is the sync byte of a packet |
| in_uncorr | input | 1 | Packet uncorrectable (sampled with the sync byte) |
| in_frame_start | input | 1 | Packet begins a superframe (sampled with the sync byte) |
| byp_bit | input | 1 | Raw inner-decoder bit for bypass |
| byp_clk | input | 1 | Clock of the raw bypass stream |
| out_data | output | 8 | Output data bus (bit 0 only in serial and bypass) |
| out_clk | output | 1 | Output clock |
| out_den | output | 1 | Data-enable, polarity per cfg_inv[0] |
| out_psync | output | 1 | Packet-sync, polarity per cfg_inv[1] |
| out_err | output | 1 | Uncorrectable-packet flag, polarity per cfg_inv[2] |
| out_fstart | output | 1 | Superframe start, polarity per cfg_inv[3] |

## Verification
The bench logs every rising edge of the output clock and compares the log, packet by packet, with byte patterns computed from packet and byte index. The mode is switched in the middle of a packet, to serial and later to bypass. A port that switched mid-packet would produce a log of the wrong length, or serial bits in place of parallel bytes. The uncorrectable flag is toggled on non-start bytes; an error flag that tracked each byte rather than being held per packet would break the error comparison. Idle gaps between bytes catch an enable, or a frame-start wider than one output period, that fires in empty slots. A sweep over all sixteen polarity settings exposes any swapped or missing inversion, both at idle and during traffic.

// File: rtl/tsout_pkg.sv
`timescale 1ns/1ps
package tsout_pkg;

   typedef enum logic [1:0] {
      MODE_PAR = 2'b00,
      MODE_SER = 2'b01,
      MODE_BYP = 2'b10,
      MODE_RSV = 2'b11
   } tsout_mode_e;

   localparam int CTL_N    = 4;
   localparam int CTL_DEN  = 0;
   localparam int CTL_SYNC = 1;
   localparam int CTL_ERR  = 2;
   localparam int CTL_FRM  = 3;

   function automatic tsout_mode_e mode_decode(input logic [1:0] sel);
      case (sel)
         2'b01:   return MODE_SER;
         2'b10:   return MODE_BYP;
         default: return MODE_PAR;
      endcase
   endfunction

endpackage

// File: rtl/tsout_pkt_tracker.sv
`timescale 1ns/1ps
module tsout_pkt_tracker
   import tsout_pkg::*;
#(
   parameter int PKT_LEN = 188,
   localparam int CW     = $clog2(PKT_LEN)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch_win,
   input  logic          fetch,
   input  logic          pkt_start,
   input  logic          uncorr,
   input  logic [1:0]    cfg_mode,
   output tsout_mode_e   cur_mode,
   output tsout_mode_e   act_mode,
   output logic          err_now,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] LAST = CW'(PKT_LEN - 1);

   tsout_mode_e req_mode;
   logic        boundary;
   logic        pkt_err_q;

   assign req_mode = mode_decode(cfg_mode);
   assign boundary = (cnt == '0);
   assign cur_mode = (launch_win && boundary) ? req_mode : act_mode;
   assign err_now  = pkt_start ? uncorr : pkt_err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_mode  <= MODE_PAR;
         pkt_err_q <= 1'b0;
         cnt       <= '0;
      end else begin
         if (launch_win && boundary)
            act_mode <= req_mode;
         if (fetch) begin
            pkt_err_q <= err_now;
            if (pkt_start)
               cnt <= CW'(1);
            else if (cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + CW'(1);
         end
      end
   end

endmodule

// File: rtl/tsout_slot_engine.sv
`timescale 1ns/1ps
module tsout_slot_engine
   import tsout_pkg::*;
#(
   parameter int DW = 8,
   localparam int BLW = (DW > 2) ? $clog2(DW) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  tsout_mode_e       cur_mode,
   input  logic              fetch,
   input  logic [DW-1:0]     in_data,
   input  logic              ps_in,
   input  logic              err_in,
   input  logic              fs_in,
   input  logic              byp_bit,
   input  logic              byp_clk,
   output logic              launch_win,
   output logic [DW-1:0]     out_data,
   output logic              out_clk,
   output logic [CTL_N-1:0]  ctl_raw
);

   localparam logic [BLW-1:0] BITS_PER_BYTE_M1 = BLW'(DW - 1);

   logic              ph;
   logic [BLW-1:0]    bits_left;
   logic [DW-1:0]     shreg;
   logic              err_hold;
   logic [DW-1:0]     data_q;
   logic              clk_q;
   logic [CTL_N-1:0]  ctl_q;

   assign launch_win = ph && (bits_left == '0);

   function automatic logic [DW-1:0] on_bit0(input logic b);
      logic [DW-1:0] v;
      v    = '0;
      v[0] = b;
      return v;
   endfunction

   function automatic logic [CTL_N-1:0] ctl_word(input logic den, input logic sy,
                                                 input logic er, input logic fr);
      logic [CTL_N-1:0] v;
      v           = '0;
      v[CTL_DEN]  = den;
      v[CTL_SYNC] = sy;
      v[CTL_ERR]  = er;
      v[CTL_FRM]  = fr;
      return v;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= 1'b0;
         bits_left <= '0;
         shreg     <= '0;
         err_hold  <= 1'b0;
         data_q    <= '0;
         clk_q     <= 1'b0;
         ctl_q     <= '0;
      end else begin
         ph <= ~ph;
         if (cur_mode == MODE_BYP) begin
            data_q    <= on_bit0(byp_bit);
            clk_q     <= byp_clk;
            ctl_q     <= '0;
            bits_left <= '0;
         end else begin
            clk_q <= ~ph;
            if (ph) begin
               if (bits_left != '0) begin
                  data_q    <= on_bit0(shreg[DW-1]);
                  shreg     <= shreg << 1;
                  bits_left <= bits_left - BLW'(1);
                  ctl_q     <= ctl_word(1'b1, 1'b0, err_hold, 1'b0);
               end else if (fetch) begin
                  err_hold <= err_in;
                  ctl_q    <= ctl_word(1'b1, ps_in, err_in, fs_in);
                  if (cur_mode == MODE_SER) begin
                     data_q    <= on_bit0(in_data[DW-1]);
                     shreg     <= in_data << 1;
                     bits_left <= BITS_PER_BYTE_M1;
                  end else begin
                     data_q <= in_data;
                  end
               end else begin
                  ctl_q <= '0;
               end
            end
         end
      end
   end

   assign out_data = data_q;
   assign out_clk  = clk_q;
   assign ctl_raw  = ctl_q;

endmodule

// File: rtl/tsout_polarity.sv
`timescale 1ns/1ps
module tsout_polarity #(
   parameter int N = 4
)(
   input  logic [N-1:0] raw,
   input  logic [N-1:0] inv,
   output logic [N-1:0] pin
);

   for (genvar i = 0; i < N; i++) begin : g_pol
      assign pin[i] = raw[i] ^ inv[i];
   end

endmodule

// File: rtl/tsout_port.sv
`timescale 1ns/1ps
module tsout_port
   import tsout_pkg::*;
#(
   parameter int DW      = 8,
   parameter int PKT_LEN = 188
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_mode,
   input  logic [3:0]    cfg_inv,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   input  logic          in_pkt_start,
   input  logic          in_uncorr,
   input  logic          in_frame_start,
   input  logic          byp_bit,
   input  logic          byp_clk,
   output logic [DW-1:0] out_data,
   output logic          out_clk,
   output logic          out_den,
   output logic          out_psync,
   output logic          out_err,
   output logic          out_fstart
);

   localparam int CNT_W = $clog2(PKT_LEN);

   if (DW < 2) begin : g_bad_dw
      $error("tsout_port: DW must be at least 2");
   end
   if (PKT_LEN < 2) begin : g_bad_len
      $error("tsout_port: PKT_LEN must be at least 2");
   end
   if (CTL_N != 4) begin : g_bad_ctl
      $error("tsout_port: control vector width mismatch");
   end

   tsout_mode_e        cur_mode;
   tsout_mode_e        act_mode;
   logic               launch_win;
   logic               fetch;
   logic               err_now;
   logic [CNT_W-1:0]   pkt_cnt;
   logic [CTL_N-1:0]   ctl_raw;
   logic [CTL_N-1:0]   ctl_pin;

   assign in_ready = launch_win && (cur_mode != MODE_BYP);
   assign fetch    = in_ready && in_valid;

   tsout_pkt_tracker #(.PKT_LEN(PKT_LEN)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_win (launch_win),
      .fetch      (fetch),
      .pkt_start  (in_pkt_start),
      .uncorr     (in_uncorr),
      .cfg_mode   (cfg_mode),
      .cur_mode   (cur_mode),
      .act_mode   (act_mode),
      .err_now    (err_now),
      .cnt        (pkt_cnt)
   );

   tsout_slot_engine #(.DW(DW)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_mode   (cur_mode),
      .fetch      (fetch),
      .in_data    (in_data),
      .ps_in      (in_pkt_start),
      .err_in     (err_now),
      .fs_in      (in_pkt_start && in_frame_start),
      .byp_bit    (byp_bit),
      .byp_clk    (byp_clk),
      .launch_win (launch_win),
      .out_data   (out_data),
      .out_clk    (out_clk),
      .ctl_raw    (ctl_raw)
   );

   tsout_polarity #(.N(CTL_N)) u_pol (
      .raw (ctl_raw),
      .inv (cfg_inv),
      .pin (ctl_pin)
   );

   assign out_den    = ctl_pin[CTL_DEN];
   assign out_psync  = ctl_pin[CTL_SYNC];
   assign out_err    = ctl_pin[CTL_ERR];
   assign out_fstart = ctl_pin[CTL_FRM];

endmodule

// File: rtl/tsout_port_chk.sv
`timescale 1ns/1ps
module tsout_port_chk
   import tsout_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 8
)(
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] out_data,
   input logic          out_clk,
   input logic          out_den,
   input logic          out_psync,
   input logic          out_err,
   input logic          out_fstart,
   input logic [3:0]    cfg_inv,
   input logic          byp_bit,
   input logic          byp_clk,
   input logic [1:0]    act_mode,
   input logic [CW-1:0] pkt_cnt
);

   logic den_r, sync_r, err_r, frm_r;
   assign den_r  = out_den    ^ cfg_inv[0];
   assign sync_r = out_psync  ^ cfg_inv[1];
   assign err_r  = out_err    ^ cfg_inv[2];
   assign frm_r  = out_fstart ^ cfg_inv[3];

   // R1
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode != MODE_BYP && !out_clk) |=> $stable(out_data));

   // R3
   sync_needs_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_r |-> den_r);

   // R4
   err_needs_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_r |-> den_r);

   // R5
   frame_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_r |-> sync_r);

   // R6
   serial_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == MODE_SER && den_r) |-> (out_data[DW-1:1] == '0));

   // R8
   bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == MODE_BYP) |-> (out_data[0] == $past(byp_bit) &&
                                  out_clk == $past(byp_clk) && !den_r));

   // R9
   mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode != $past(act_mode)) |-> ($past(pkt_cnt) == '0));

endmodule

bind tsout_port tsout_port_chk #(.DW(DW), .CW(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_data   (out_data),
   .out_clk    (out_clk),
   .out_den    (out_den),
   .out_psync  (out_psync),
   .out_err    (out_err),
   .out_fstart (out_fstart),
   .cfg_inv    (cfg_inv),
   .byp_bit    (byp_bit),
   .byp_clk    (byp_clk),
   .act_mode   (act_mode),
   .pkt_cnt    (pkt_cnt)
);

// File: tb/tsout_port_test.sv
`timescale 1ns/1ps
module tsout_port_test;

   localparam int PL = 188;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic [3:0] cfg_inv = 4'h0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       in_pkt_start = 1'b0;
   logic       in_uncorr = 1'b0;
   logic       in_frame_start = 1'b0;
   logic       byp_bit = 1'b0;
   logic       byp_clk = 1'b0;
   logic [7:0] out_data;
   logic       out_clk, out_den, out_psync, out_err, out_fstart;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0] lg_d[$];
   bit         lg_ps[$];
   bit         lg_er[$];
   bit         lg_fs[$];
   int         stray = 0;
   logic       prev_clk = 1'b0;

   tsout_port uut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_inv(cfg_inv),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_pkt_start(in_pkt_start), .in_uncorr(in_uncorr),
      .in_frame_start(in_frame_start), .byp_bit(byp_bit), .byp_clk(byp_clk),
      .out_data(out_data), .out_clk(out_clk), .out_den(out_den),
      .out_psync(out_psync), .out_err(out_err), .out_fstart(out_fstart)
   );

   always #10 clk = ~clk;

   // log every rising edge of the output clock, decoded to raw polarity
   always @(negedge clk) begin
      if (rst_n && !prev_clk && out_clk) begin
         if (out_den ^ cfg_inv[0]) begin
            lg_d.push_back(out_data);
            lg_ps.push_back(out_psync ^ cfg_inv[1]);
            lg_er.push_back(out_err ^ cfg_inv[2]);
            lg_fs.push_back(out_fstart ^ cfg_inv[3]);
         end else if ((out_psync ^ cfg_inv[1]) || (out_err ^ cfg_inv[2]) ||
                      (out_fstart ^ cfg_inv[3])) begin
            stray++;
         end
      end
      prev_clk = out_clk;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input int p, input int k);
      if (k == 0) return 8'h47;
      return 8'(p * 37 + k * 11 + 3);
   endfunction

   task automatic put_byte(input logic [7:0] d, input bit ps, input bit ue, input bit fs);
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_pkt_start = ps;
      in_uncorr = ue; in_frame_start = fs;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0; in_pkt_start = 1'b0; in_frame_start = 1'b0;
   endtask

   // uncorrectable flag is inverted on non-start bytes: only the sync byte counts (R4)
   task automatic send_pkt(input int p, input bit ue, input bit fr, input bit gaps,
                           input int sw_at, input logic [1:0] sw_mode);
      for (int k = 0; k < PL; k++) begin
         if (k == sw_at) cfg_mode = sw_mode;
         if (gaps) repeat (k % 3) @(negedge clk);
         put_byte(pbyte(p, k), k == 0, (k == 0) ? ue : !ue, (k == 0) ? fr : 1'b1);
      end
   endtask

   task automatic log_clear();
      lg_d.delete(); lg_ps.delete(); lg_er.delete(); lg_fs.delete();
      stray = 0;
   endtask

   task automatic log_end(input int n_exp);
      repeat (60) @(negedge clk);
      // R2: one logged slot per byte (parallel) or bit (serial), nothing in idle slots
      chk(lg_d.size() == n_exp, "R2 enabled slot count", lg_d.size(), n_exp);
      chk(stray == 0, "R2 controls active while enable low", stray, 0);
   endtask

   task automatic check_pkt(input int base, input int p, input bit ser,
                            input bit ue, input bit fr);
      int n;
      int bd, bp, be, bf;
      logic [7:0] b;
      logic [7:0] ed;
      n  = ser ? PL * 8 : PL;
      bd = 0; bp = 0; be = 0; bf = 0;
      for (int k = 0; k < n; k++) begin
         int idx;
         idx = base + k;
         if (idx >= lg_d.size()) begin
            bd++;
            continue;
         end
         b = pbyte(p, ser ? k / 8 : k);
         ed = ser ? {7'b0, b[7 - (k % 8)]} : b;
         if (lg_d[idx] != ed) bd++;
         if (lg_ps[idx] != (k == 0)) bp++;
         if (lg_er[idx] != ue) be++;
         if (lg_fs[idx] != (fr && k == 0)) bf++;
      end
      if (ser) chk(bd == 0, "R6 serial bits MSB first on bit 0", bd, 0);
      else     chk(bd == 0, "R1 parallel bytes", bd, 0);
      chk(bp == 0, "R3 packet-sync placement", bp, 0);
      chk(be == 0, "R4 error held over packet", be, 0);
      chk(bf == 0, "R5 single-period frame start", bf, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk(out_clk == 1'b0, "R10 out_clk in reset", out_clk, 0);
      chk(out_data == 8'h00, "R10 out_data in reset", out_data, 0);
      chk(in_ready == 1'b0, "R10 in_ready in reset", in_ready, 0);
      chk({out_fstart, out_err, out_psync, out_den} == 4'h0,
          "R10 controls in reset", {out_fstart, out_err, out_psync, out_den}, 0);
      rst_n = 1'b1;

      // R1: output clock toggles every system cycle
      repeat (3) @(negedge clk);
      begin
         logic p0;
         int bad;
         bad = 0;
         p0 = out_clk;
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (out_clk == p0) bad++;
            p0 = out_clk;
         end
         chk(bad == 0, "R1 output clock toggle", bad, 0);
      end

      // back-to-back parallel packets
      log_clear();
      send_pkt(1, 1'b0, 1'b1, 1'b0, -1, 2'b00);
      send_pkt(2, 1'b1, 1'b0, 1'b0, -1, 2'b00);
      send_pkt(3, 1'b0, 1'b0, 1'b0, -1, 2'b00);
      log_end(3 * PL);
      check_pkt(0, 1, 1'b0, 1'b0, 1'b1);
      check_pkt(PL, 2, 1'b0, 1'b1, 1'b0);
      check_pkt(2 * PL, 3, 1'b0, 1'b0, 1'b0);

      // idle gaps between bytes, reserved mode code acts as parallel
      cfg_mode = 2'b11;
      log_clear();
      send_pkt(4, 1'b1, 1'b1, 1'b1, -1, 2'b11);
      log_end(PL);
      check_pkt(0, 4, 1'b0, 1'b1, 1'b1);

      // R7: polarity sweep
      cfg_mode = 2'b00;
      for (int v = 0; v < 16; v++) begin
         int p_bad;
         @(negedge clk);
         cfg_inv = 4'(v);
         repeat (4) @(negedge clk);
         chk({out_fstart, out_err, out_psync, out_den} == 4'(v),
             "R7 idle pin levels", {out_fstart, out_err, out_psync, out_den}, v);
         log_clear();
         send_pkt(10 + v, v[0], v[1], 1'b0, -1, 2'b00);
         log_end(PL);
         p_bad = fails;
         check_pkt(0, 10 + v, 1'b0, v[0], v[1]);
         chk(fails == p_bad, "R7 decoded traffic under inversion", fails - p_bad, 0);
      end
      @(negedge clk);
      cfg_inv = 4'h0;

      // R9: request serial mid-packet; current packet stays parallel
      log_clear();
      send_pkt(5, 1'b0, 1'b0, 1'b0, 60, 2'b01);
      send_pkt(6, 1'b1, 1'b1, 1'b0, -1, 2'b01);
      log_end(PL + PL * 8);
      check_pkt(0, 5, 1'b0, 1'b0, 1'b0);
      check_pkt(PL, 6, 1'b1, 1'b1, 1'b1);

      // R9: request bypass mid-packet; serial packet completes
      log_clear();
      send_pkt(7, 1'b0, 1'b1, 1'b0, 100, 2'b10);
      log_end(PL * 8);
      check_pkt(0, 7, 1'b1, 1'b0, 1'b1);

      // R8: bypass follows raw stream, input stalled
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hA5;
      begin
         int bad_d, bad_c, bad_r, bad_k;
         bad_d = 0; bad_c = 0; bad_r = 0; bad_k = 0;
         for (int i = 0; i < 16; i++) begin
            logic eb, ec;
            @(negedge clk);
            eb = 1'(i ^ (i >> 2));
            ec = 1'(i >> 1);
            byp_bit = eb; byp_clk = ec;
            @(negedge clk);
            #1;
            if (out_data != {7'b0, eb}) bad_d++;
            if (out_clk != ec) bad_c++;
            if (in_ready) bad_r++;
            if ({out_fstart, out_err, out_psync, out_den} != 4'h0) bad_k++;
         end
         chk(bad_d == 0, "R8 bypass data on bit 0", bad_d, 0);
         chk(bad_c == 0, "R8 bypass clock", bad_c, 0);
         chk(bad_r == 0, "R8 in_ready low in bypass", bad_r, 0);
         chk(bad_k == 0, "R8 controls inactive in bypass", bad_k, 0);
      end
      in_valid = 1'b0; byp_clk = 1'b0; byp_bit = 1'b0;

      // leave bypass, resume parallel traffic
      cfg_mode = 2'b00;
      repeat (6) @(negedge clk);
      log_clear();
      send_pkt(9, 1'b1, 1'b0, 1'b0, -1, 2'b00);
      log_end(PL);
      check_pkt(0, 9, 1'b0, 1'b1, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule